// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Controller

This block keeps an asynchronous DRAM's contents alive. It issues CAS-before-RAS refresh cycles, where the device's own row counter picks the row, so the block never drives an address. In distributed mode it owes one refresh per interval. In burst mode it owes a full sweep of all rows once per interval multiplied by the row count. When the block owes refresh work, it raises a request to the access arbiter. It drives the strobe overrides only after the arbiter grants the bus, and it keeps the bus until the owed work is finished.

The block also takes commands to enter and leave the device's low-power self-refresh state. On entry it starts a CBR cycle and holds RAS low for at least the hold time. On exit it releases both strobes and waits out a recovery time before it drives any other cycle. In burst mode a sweep over every row follows the exit before the bus is handed back.

Interval, row count, strobe timings, hold and recovery times, and the deferral limit are parameters, all counted in clock cycles.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_o=0, ras_n_o=1, cas_n_o=1, busy_o=0 and sr_active_o=0.
- R2: In distributed mode with the grant held high, exactly one refresh completes every REF_INTERVAL cycles.
- R3: Each refresh cycle lowers cas_n_o first and lowers ras_n_o exactly CAS_LEAD cycles later. RAS stays low for exactly RAS_LOW cycles, then both strobes rise in the same cycle. Both strobes then stay high for at least PRECHARGE cycles before CAS falls again.
- R4: While refresh is owed and the grant is low, req_o stays high and both strobes stay high. Strobes start only from a cycle in which grant_i was high, or while the block already owns the bus.
- R5: Refreshes that are deferred because the grant is withheld accumulate up to PEND_MAX. Any beyond that are lost. After the grant returns, the accumulated refreshes are issued back to back, with exactly PRECHARGE cycles between them.
- R6: An enter command starts a CBR cycle. RAS then stays low for exactly SR_HOLD cycles before sr_active_o rises. While self refresh lasts, both strobes stay low and no refresh cycle is issued.
- R7: An exit command raises both strobes. CAS stays high for at least SR_RECOVER cycles. In distributed mode busy_o falls exactly SR_RECOVER cycles after the release, and the interval timer restarts, so the first refresh CAS falls SR_RECOVER+REF_INTERVAL+2 cycles after the release.
- R8: In burst mode with the grant held high, a run of ROW_COUNT back-to-back refreshes starts every REF_INTERVAL*ROW_COUNT cycles.
- R9: In burst mode, CAS falls exactly SR_RECOVER cycles after the self-refresh release. A run of ROW_COUNT back-to-back refreshes then follows before the bus is released.
- R10: An enter command is accepted only while the block is idle or waiting for a grant to a refresh. One that arrives while strobes are being driven (for example during a burst) is discarded.
- R11: busy_o is high exactly while the block owns the bus: during refresh strobes, precharge, and the self-refresh entry, hold and recovery. busy_o implies req_o.
- R12: An exit command has no effect unless self refresh is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Arbiter grant, sampled while requesting |
| sr_enter_i | input | 1 | Enter self refresh command pulse |
| sr_exit_i | input | 1 | Leave self refresh command pulse |
| req_o | output | 1 | Bus request to the arbiter |
| ras_n_o | output | 1 | RAS override, active low |
| cas_n_o | output | 1 | CAS override, active low |
| busy_o | output | 1 | Block owns the bus |
| sr_active_o | output | 1 | Device is held in self refresh |

## Verification
Every strobe output is decoded straight from the sequencer state register. An input seen at a clock edge therefore shows on the strobes in the following cycle. A pending refresh reaches CAS two cycles after the interval tick: one cycle to update the pending count and one in the request state. The bench samples each output shortly after the falling clock edge and keeps a cycle count there. From that count a monitor measures the CAS lead, RAS width, precharge gap and self-refresh hold. The checks of release-to-busy and release-to-first-CAS compare the measured counts with the offsets stated in R7 and R9. Checks over long windows use window ends placed half an interval away from any expected event, so they do not depend on which edge an event lands on.

// File: rtl/dref_pkg.sv
// Shared types and helpers for the DRAM refresh controller.
package dref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_REQ    = 3'd1,
        ST_CAS    = 3'd2,
        ST_RAS    = 3'd3,
        ST_PRE    = 3'd4,
        ST_SRHOLD = 3'd5,
        ST_SR     = 3'd6,
        ST_SRX    = 3'd7
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_tick_timer.sv
// Interval timer: pulses tick_o once every PERIOD enabled cycles.
// Assumes PERIOD >= 2. When disabled the count returns to zero, so the
// next tick comes a full PERIOD after enable is restored.
module dref_tick_timer #(
    parameter int PERIOD = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;

    assign tick_o = en_i && (cnt == CW'(PERIOD - 1));

    // Count enabled cycles, wrap on tick, clear while paused.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dref_pend_ctr.sv
// Owed-refresh counter: adds AMT per tick, subtracts one per completed
// refresh, saturates at LIMIT. Clear wins over fill, fill over arithmetic.
// Assumes sub_i is only raised while the count is nonzero.
module dref_pend_ctr #(
    parameter int AMT   = 1,
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic sub_i,
    input  logic fill_i,
    input  logic clr_i,
    output logic nz_o
);
    localparam int PW = $clog2(LIMIT + AMT + 1);

    logic [PW-1:0] cnt;
    logic [PW-1:0] nxt;

    // Next count with saturation at the limit.
    always_comb begin
        nxt = cnt;
        if (add_i) nxt = nxt + PW'(AMT);
        if (sub_i && nxt != '0) nxt = nxt - 1'b1;
        if (nxt > PW'(LIMIT)) nxt = PW'(LIMIT);
    end

    // Hold the owed count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (fill_i) begin
            cnt <= PW'(LIMIT);
        end else begin
            cnt <= nxt;
        end
    end

    assign nz_o = (cnt != '0);
endmodule

// File: rtl/dref_cycle_seq.sv
// Strobe sequencer: requests the bus, runs CBR refresh cycles, and walks
// the self-refresh entry, hold, stay and recovery phases. Outputs decode
// straight from the state register. Assumes every timing parameter >= 1
// and that the arbiter keeps granting once the strobes have started.
module dref_cycle_seq
    import dref_pkg::*;
#(
    parameter int CAS_LEAD    = 2,
    parameter int RAS_LOW     = 3,
    parameter int PRECHARGE   = 2,
    parameter int SR_HOLD     = 6,
    parameter int SR_RECOVER  = 5,
    parameter bit DISTRIBUTED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic enter_i,
    input  logic exit_i,
    input  logic pend_nz_i,
    output logic done_o,
    output logic fill_o,
    output logic pause_o,
    output logic clr_o,
    output logic req_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic busy_o,
    output logic sr_o
);
    localparam int TMAX = imax(imax(imax(CAS_LEAD, RAS_LOW), imax(PRECHARGE, SR_HOLD)), SR_RECOVER);
    localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX);

    seq_state_t    state, state_nx;
    logic [TW-1:0] tcnt, tcnt_nx;
    logic          for_sr, for_sr_nx;
    logic          enter_pend;
    logic          take_sr;
    logic          t_zero;

    assign t_zero  = (tcnt == '0);
    assign take_sr = (state == ST_IDLE) && !pend_nz_i && enter_pend;

    // Next state, phase timer and entry-purpose flag.
    always_comb begin
        state_nx  = state;
        tcnt_nx   = t_zero ? tcnt : tcnt - 1'b1;
        for_sr_nx = for_sr;
        unique case (state)
            ST_IDLE: begin
                if (pend_nz_i) begin
                    state_nx  = ST_REQ;
                    for_sr_nx = 1'b0;
                end else if (enter_pend) begin
                    state_nx  = ST_REQ;
                    for_sr_nx = 1'b1;
                end
            end
            ST_REQ: begin
                if (grant_i) begin
                    state_nx = ST_CAS;
                    tcnt_nx  = TW'(CAS_LEAD - 1);
                end
            end
            ST_CAS: begin
                if (t_zero) begin
                    state_nx = for_sr ? ST_SRHOLD : ST_RAS;
                    tcnt_nx  = for_sr ? TW'(SR_HOLD - 1) : TW'(RAS_LOW - 1);
                end
            end
            ST_RAS: begin
                if (t_zero) begin
                    state_nx = ST_PRE;
                    tcnt_nx  = TW'(PRECHARGE - 1);
                end
            end
            ST_PRE: begin
                if (t_zero) begin
                    state_nx = pend_nz_i ? ST_CAS : ST_IDLE;
                    tcnt_nx  = TW'(CAS_LEAD - 1);
                end
            end
            ST_SRHOLD: begin
                if (t_zero) state_nx = ST_SR;
            end
            ST_SR: begin
                if (exit_i) begin
                    state_nx = ST_SRX;
                    tcnt_nx  = TW'(SR_RECOVER - 1);
                end
            end
            ST_SRX: begin
                if (t_zero) begin
                    state_nx  = DISTRIBUTED ? ST_IDLE : ST_CAS;
                    tcnt_nx   = TW'(CAS_LEAD - 1);
                    for_sr_nx = 1'b0;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State, timer and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            for_sr <= 1'b0;
        end else begin
            state  <= state_nx;
            tcnt   <= tcnt_nx;
            for_sr <= for_sr_nx;
        end
    end

    // Latch an enter command only while idle or waiting to refresh.
    always_ff @(posedge clk) begin
        if (!rst_n || take_sr) begin
            enter_pend <= 1'b0;
        end else if (enter_i && (state == ST_IDLE || (state == ST_REQ && !for_sr))) begin
            enter_pend <= 1'b1;
        end
    end

    assign done_o  = (state == ST_RAS) && t_zero;
    assign fill_o  = !DISTRIBUTED && (state == ST_SRX) && t_zero;
    assign pause_o = (state == ST_SRHOLD) || (state == ST_SR) || (state == ST_SRX);
    assign clr_o   = (state == ST_SR);
    assign req_o   = (state != ST_IDLE);
    assign busy_o  = (state != ST_IDLE) && (state != ST_REQ);
    assign sr_o    = (state == ST_SR);
    assign ras_n_o = !((state == ST_RAS) || (state == ST_SRHOLD) || (state == ST_SR));
    assign cas_n_o = !((state == ST_CAS) || (state == ST_RAS) ||
                       (state == ST_SRHOLD) || (state == ST_SR));
endmodule

// File: rtl/dram_refresh_ctrl.sv
// DRAM refresh controller top: interval timer, owed-refresh counter and
// strobe sequencer. DISTRIBUTED=1 owes one refresh per REF_INTERVAL;
// DISTRIBUTED=0 owes ROW_COUNT refreshes per REF_INTERVAL*ROW_COUNT and
// sweeps all rows after each self-refresh exit. All times in cycles.
module dram_refresh_ctrl #(
    parameter int REF_INTERVAL = 12500,
    parameter int ROW_COUNT    = 4096,
    parameter int CAS_LEAD     = 2,
    parameter int RAS_LOW      = 6,
    parameter int PRECHARGE    = 5,
    parameter int SR_HOLD      = 10000,
    parameter int SR_RECOVER   = 11000,
    parameter int PEND_MAX     = 8,
    parameter bit DISTRIBUTED  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic sr_enter_i,
    input  logic sr_exit_i,
    output logic req_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic busy_o,
    output logic sr_active_o
);
    localparam int PERIOD = DISTRIBUTED ? REF_INTERVAL : REF_INTERVAL * ROW_COUNT;
    localparam int AMT    = DISTRIBUTED ? 1 : ROW_COUNT;
    localparam int LIMIT  = DISTRIBUTED ? PEND_MAX : ROW_COUNT;

    logic tick, pend_nz, done, fill, pause, clr;

    dref_tick_timer #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (!pause),
        .tick_o (tick)
    );

    dref_pend_ctr #(.AMT(AMT), .LIMIT(LIMIT)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_i  (tick),
        .sub_i  (done),
        .fill_i (fill),
        .clr_i  (clr),
        .nz_o   (pend_nz)
    );

    dref_cycle_seq #(
        .CAS_LEAD    (CAS_LEAD),
        .RAS_LOW     (RAS_LOW),
        .PRECHARGE   (PRECHARGE),
        .SR_HOLD     (SR_HOLD),
        .SR_RECOVER  (SR_RECOVER),
        .DISTRIBUTED (DISTRIBUTED)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_i   (grant_i),
        .enter_i   (sr_enter_i),
        .exit_i    (sr_exit_i),
        .pend_nz_i (pend_nz),
        .done_o    (done),
        .fill_o    (fill),
        .pause_o   (pause),
        .clr_o     (clr),
        .req_o     (req_o),
        .ras_n_o   (ras_n_o),
        .cas_n_o   (cas_n_o),
        .busy_o    (busy_o),
        .sr_o      (sr_active_o)
    );
endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
// Port-level protocol checker for dram_refresh_ctrl, bound to every instance.
module dram_refresh_ctrl_chk #(
    parameter int SR_RECOVER = 5
) (
    input logic clk,
    input logic rst_n,
    input logic grant_i,
    input logic req_o,
    input logic ras_n_o,
    input logic cas_n_o,
    input logic busy_o,
    input logic sr_active_o
);
    int since_rel;

    // Cycles since self refresh was left, saturating at the recovery time.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rel <= SR_RECOVER;
        else if (sr_active_o) since_rel <= 0;
        else if (since_rel < SR_RECOVER) since_rel <= since_rel + 1;
    end

    a_r3_ras_needs_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> !cas_n_o);
    a_r3_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> $past(!cas_n_o));
    a_r4_grant_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n_o) && $past(!busy_o)) |-> $past(grant_i));
    a_r11_busy_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> req_o);
    a_r11_strobe_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> busy_o);
    a_r6_sr_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active_o |-> (!ras_n_o && !cas_n_o));
    a_r7_recovery_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_active_o && since_rel < SR_RECOVER) |-> (cas_n_o && ras_n_o));
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.SR_RECOVER(SR_RECOVER)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_i     (grant_i),
    .req_o       (req_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .busy_o      (busy_o),
    .sr_active_o (sr_active_o)
);

// File: tb/dram_refresh_ctrl_tb_top.sv
// Strobe monitor: measures each CBR cycle and self-refresh hold at negedge.
module dref_strobe_mon #(
    parameter int CAS_LEAD  = 2,
    parameter int RAS_LOW   = 3,
    parameter int PRECHARGE = 2,
    parameter int SR_HOLD   = 6
) (
    input logic clk,
    input logic ras_n,
    input logic cas_n,
    input logic sr
);
    int cyc = 0, cas_fall_cyc = -1000, ras_fall_cyc = -1000, ras_rise_cyc = -1000;
    int refreshes = 0, cas_falls = 0, run_len = 0, start_gap = 0, start_cyc = 0;
    int chk = 0, bad = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, sr_low = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (p_cas === 1'b1 && cas_n === 1'b0) begin
            cas_falls++;
            chk++;
            if (cyc - ras_rise_cyc < PRECHARGE) begin
                bad++;
                $display("FAIL R3 precharge gap act=%0d exp>=%0d", cyc - ras_rise_cyc, PRECHARGE);
            end
            if (cyc - ras_rise_cyc == PRECHARGE) run_len++;
            else begin
                run_len   = 1;
                start_gap = cyc - ras_rise_cyc;
                start_cyc = cyc;
            end
            cas_fall_cyc = cyc;
        end
        if (p_ras === 1'b1 && ras_n === 1'b0) begin
            chk++;
            if (cyc - cas_fall_cyc != CAS_LEAD) begin
                bad++;
                $display("FAIL R3 cas lead act=%0d exp=%0d", cyc - cas_fall_cyc, CAS_LEAD);
            end
            ras_fall_cyc = cyc;
            sr_low = 1'b0;
        end
        if (sr === 1'b1 && !sr_low) begin
            sr_low = 1'b1;
            chk++;
            if (cyc - ras_fall_cyc != SR_HOLD) begin
                bad++;
                $display("FAIL R6 hold act=%0d exp=%0d", cyc - ras_fall_cyc, SR_HOLD);
            end
        end
        if (p_ras === 1'b0 && ras_n === 1'b1) begin
            ras_rise_cyc = cyc;
            if (!sr_low) begin
                refreshes++;
                chk++;
                if (cyc - ras_fall_cyc != RAS_LOW) begin
                    bad++;
                    $display("FAIL R3 ras width act=%0d exp=%0d", cyc - ras_fall_cyc, RAS_LOW);
                end
            end
        end
        p_ras = ras_n;
        p_cas = cas_n;
    end
endmodule

// Bench: one distributed and one burst instance of a small configuration.
module dram_refresh_ctrl_tb_top;
    localparam int I  = 40;
    localparam int RW = 4;
    localparam int CL = 2;
    localparam int RL = 3;
    localparam int PR = 2;
    localparam int SH = 6;
    localparam int SX = 5;
    localparam int PM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt_a = 1'b1, ent_a = 1'b0, ext_a = 1'b0;
    logic gnt_b = 1'b1, ent_b = 1'b0, ext_b = 1'b0;
    logic req_a, ras_a, cas_a, busy_a, sr_a;
    logic req_b, ras_b, cas_b, busy_b, sr_b;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dram_refresh_ctrl #(.REF_INTERVAL(I), .ROW_COUNT(RW), .CAS_LEAD(CL), .RAS_LOW(RL),
        .PRECHARGE(PR), .SR_HOLD(SH), .SR_RECOVER(SX), .PEND_MAX(PM), .DISTRIBUTED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .grant_i(gnt_a), .sr_enter_i(ent_a), .sr_exit_i(ext_a),
        .req_o(req_a), .ras_n_o(ras_a), .cas_n_o(cas_a), .busy_o(busy_a), .sr_active_o(sr_a));

    dram_refresh_ctrl #(.REF_INTERVAL(I), .ROW_COUNT(RW), .CAS_LEAD(CL), .RAS_LOW(RL),
        .PRECHARGE(PR), .SR_HOLD(SH), .SR_RECOVER(SX), .PEND_MAX(PM), .DISTRIBUTED(1'b0)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .grant_i(gnt_b), .sr_enter_i(ent_b), .sr_exit_i(ext_b),
        .req_o(req_b), .ras_n_o(ras_b), .cas_n_o(cas_b), .busy_o(busy_b), .sr_active_o(sr_b));

    dref_strobe_mon #(.CAS_LEAD(CL), .RAS_LOW(RL), .PRECHARGE(PR), .SR_HOLD(SH)) mon_a (
        .clk(clk), .ras_n(ras_a), .cas_n(cas_a), .sr(sr_a));
    dref_strobe_mon #(.CAS_LEAD(CL), .RAS_LOW(RL), .PRECHARGE(PR), .SR_HOLD(SH)) mon_b (
        .clk(clk), .ras_n(ras_b), .cas_n(cas_b), .sr(sr_b));

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==",
                 n_chk + mon_a.chk + mon_b.chk, n_bad + mon_a.bad + mon_b.bad);
    endtask

    task automatic wait_ref_a();
        int base;
        base = mon_a.refreshes;
        while (mon_a.refreshes == base) step();
    endtask

    task automatic wait_run_b();
        while (busy_b !== 1'b1) step();
        while (busy_b !== 1'b0) step();
    endtask

    initial begin
        int base, s1, rr, cf;
        step(3);
        // R1: outputs during reset and just after it
        check({req_a, ras_a, cas_a, busy_a, sr_a} == 5'b01100, "R1 dist in reset",
              int'({req_a, ras_a, cas_a, busy_a, sr_a}), 12);
        check({req_b, ras_b, cas_b, busy_b, sr_b} == 5'b01100, "R1 burst in reset",
              int'({req_b, ras_b, cas_b, busy_b, sr_b}), 12);
        rst_n = 1'b1;
        step();
        check({req_a, ras_a, cas_a, busy_a, sr_a} == 5'b01100, "R1 dist after reset",
              int'({req_a, ras_a, cas_a, busy_a, sr_a}), 12);
        check({req_b, ras_b, cas_b, busy_b, sr_b} == 5'b01100, "R1 burst after reset",
              int'({req_b, ras_b, cas_b, busy_b, sr_b}), 12);

        // R2: steady distributed rate
        wait_ref_a();
        wait_ref_a();
        base = mon_a.refreshes;
        step(10 * I - I / 2);
        check(mon_a.refreshes - base == 9, "R2 refreshes in window", mon_a.refreshes - base, 9);

        // R4, R5: withhold grant for six intervals
        wait_ref_a();
        base = mon_a.refreshes;
        step(2 * I);
        gnt_a = 1'b0;
        for (int k = 0; k < 6; k++) begin
            step(I);
            check(req_a === 1'b1, "R4 request while deferred", int'(req_a), 1);
            check(ras_a === 1'b1 && cas_a === 1'b1, "R4 strobes idle without grant",
                  int'({ras_a, cas_a}), 3);
        end
        gnt_a = 1'b1;
        step(30);
        check(mon_a.run_len == PM, "R5 backlog run length", mon_a.run_len, PM);
        step(12 * I - I / 2 - 30);
        check(mon_a.refreshes - base == 16, "R5 refreshes with loss", mon_a.refreshes - base, 16);

        // R12: exit outside self refresh
        wait_ref_a();
        step(2);
        ext_a = 1'b1;
        step();
        ext_a = 1'b0;
        for (int k = 0; k < 10; k++) begin
            check(busy_a === 1'b0 && sr_a === 1'b0 && ras_a === 1'b1, "R12 exit ignored",
                  int'({busy_a, sr_a, ras_a}), 1);
            step();
        end

        // R6, R7, R11: distributed self refresh
        ent_a = 1'b1;
        step();
        ent_a = 1'b0;
        while (sr_a !== 1'b1) step();
        base = mon_a.refreshes;
        step(3 * I);
        check(mon_a.refreshes == base, "R6 no refresh in self refresh", mon_a.refreshes - base, 0);
        check(ras_a === 1'b0 && cas_a === 1'b0, "R6 strobes held low", int'({ras_a, cas_a}), 0);
        check(busy_a === 1'b1 && sr_a === 1'b1, "R11 busy in self refresh", int'({busy_a, sr_a}), 3);
        ext_a = 1'b1;
        step();
        ext_a = 1'b0;
        while (busy_a !== 1'b0) step();
        rr = mon_a.ras_rise_cyc;
        check(mon_a.cyc - rr == SX, "R7 busy falls after recovery", mon_a.cyc - rr, SX);
        cf = mon_a.cas_falls;
        while (mon_a.cas_falls == cf) step();
        check(mon_a.cas_fall_cyc - rr == SX + I + 2, "R7 timer restart",
              mon_a.cas_fall_cyc - rr, SX + I + 2);

        // R8: burst period and run length
        wait_run_b();
        s1 = mon_b.start_cyc;
        base = mon_b.refreshes;
        wait_run_b();
        check(mon_b.start_cyc - s1 == RW * I, "R8 burst period", mon_b.start_cyc - s1, RW * I);
        check(mon_b.run_len == RW, "R8 burst run length", mon_b.run_len, RW);
        check(mon_b.refreshes - base == RW, "R8 burst refresh count", mon_b.refreshes - base, RW);

        // R10: enter during a burst is discarded
        cf = mon_b.cas_falls;
        while (mon_b.cas_falls == cf) step();
        ent_b = 1'b1;
        step();
        ent_b = 1'b0;
        while (busy_b !== 1'b0) step();
        step(20);
        check(sr_b === 1'b0 && busy_b === 1'b0 && ras_b === 1'b1, "R10 enter during burst dropped",
              int'({sr_b, busy_b, ras_b}), 1);
        check(mon_b.run_len == RW, "R10 burst undisturbed", mon_b.run_len, RW);

        // R6, R9: burst-mode self refresh and post-exit sweep
        ent_b = 1'b1;
        step();
        ent_b = 1'b0;
        while (sr_b !== 1'b1) step();
        base = mon_b.refreshes;
        step(200);
        check(mon_b.refreshes == base, "R6 burst no refresh in self refresh",
              mon_b.refreshes - base, 0);
        ext_b = 1'b1;
        step();
        ext_b = 1'b0;
        wait_run_b();
        check(mon_b.start_gap == SX, "R9 cas after recovery", mon_b.start_gap, SX);
        check(mon_b.run_len == RW, "R9 sweep after exit", mon_b.run_len, RW);
        check(mon_b.refreshes - base == RW, "R9 sweep count", mon_b.refreshes - base, RW);

        done = 1'b1;
        report();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            report();
            $finish;
        end
    end
endmodule